// File: doc/BRIEF.md
# Two-Phase Microword Processor Core

A small 16-bit processor core in which every instruction is one horizontal microword. The core alternates between two cycles. In the fetch cycle a fixed microword reads memory at the program counter, captures the word into the instruction register and increments the program counter. In the execute cycle the captured word drives the machine directly. Its fields are the bus strobes, two register selects, a flag-latch enable, a carry-in select and an ALU function.

The ALU provides sixteen logic and sixteen arithmetic functions. In logic mode the carry-in select field has no arithmetic meaning, so the core uses it as a predicate on the register-file writeback. With that predicate a compare can set flags without disturbing its operand, and a move into the program counter becomes a conditional jump. The memory/IO bus is simple. Address, write data and both strobes come from the current microword. Read data is expected back combinationally in the same cycle, and a write takes effect at the clock edge.

Top module: `cpu_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every register (program counter included) holds zero and the core sits in a fetch cycle: mem_addr = 0, mem_rd = 1, mem_wr = 0.
- R2: Fetch and execute cycles strictly alternate. A fetch reads the word at the program counter (register 7) into the instruction register and leaves the program counter one higher. The fetch microword is 0xBF80.
- R3: Instruction fields are: bit 15 read strobe, bit 14 write strobe, bits 13:11 select A (address bus, ALU A operand, writeback target), bits 10:8 select B (write data, ALU B operand). On an execute read, mem_rdata is the B operand and is loaded into register B. On an execute write, mem_addr = reg[A] and mem_wdata = reg[B].
- R4: Bit 4 chooses logic (1) or arithmetic (0) mode and bits 3:0 choose one of sixteen functions in that mode. Examples: logic 0 gives NOT A, 9 gives A XNOR B, 10 gives B, 15 gives A. Arithmetic 0 gives A plus carry, 9 gives A plus B plus carry, 15 gives A minus 1 plus carry. CY is the arithmetic carry out (0 in logic mode). EQ is set when the result is all ones.
- R5: In arithmetic mode, bits 6:5 give the carry in: 00 constant one, 01 CY flag, 10 EQ flag, 11 constant zero.
- R6: In arithmetic mode the ALU result is always written into register A.
- R7: In logic mode, bits 6:5 predicate the writeback into register A: 00 always, 01 only when CY is set, 10 only when EQ is set, 11 never.
- R8: When bit 7 is 0 in an execute cycle, CY and EQ are both loaded from the ALU, whether or not the writeback happens. When bit 7 is 1, both flags keep their value.
- R9: A predicated logic move of B into register 7 is a conditional jump. When it is taken, the next fetch is from reg[B]. When it is not taken, the next fetch is from the word after the jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | DW | Bus address, taken from register A |
| mem_wdata | output | DW | Bus write data, taken from register B |
| mem_rdata | input | DW | Bus read data, valid in the same cycle as mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
Two things can land on the same execute cycle: the flag latch and a suppressed writeback. A compare uses XNOR with the never-write code and bit 7 low, so the core must load EQ while leaving the operand intact. The bench follows it with an equal-predicated jump and then stores the operand. If the jump goes wrong or the operand is overwritten, the scoreboard sees an unexpected write address or value. A second clash is a memory read and a program-counter writeback in one cycle: load-immediate both fills register B from the bus and steps the program counter. Every later stored value depends on both of those succeeding.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [2:0] asel;
    logic [2:0] bsel;
    logic       nlatch;
    logic [1:0] csel;
    logic       mode;
    logic [3:0] fn;
  } uword_t;

  localparam int IRW = 16;
  localparam int NREG = 8;
  localparam logic [2:0] PC_IDX = 3'd7;
  localparam uword_t FETCH_WORD = 16'hBF80;

  // Carry-in selector for arithmetic mode.
  function automatic logic pick_cin(input logic [1:0] csel, input logic cy, input logic eq);
    case (csel)
      2'b00:   return 1'b1;
      2'b01:   return cy;
      2'b10:   return eq;
      default: return 1'b0;
    endcase
  endfunction

  // Writeback predicate: arithmetic always writes, logic uses csel.
  function automatic logic wb_allowed(input logic mode, input logic [1:0] csel,
                                      input logic cy, input logic eq);
    if (!mode) return 1'b1;
    case (csel)
      2'b00:   return 1'b1;
      2'b01:   return cy;
      2'b10:   return eq;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    a_idx,
  input  logic [2:0]    b_idx,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q,
  output logic [DW-1:0] pc_q,
  input  logic          wa_en,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [DW-1:0] wb_data
);
  import cpu_pkg::*;

  logic [DW-1:0] regs [NREG];

  assign a_q  = regs[a_idx];
  assign b_q  = regs[b_idx];
  assign pc_q = regs[PC_IDX];

  // Port B (bus load into B register) first; ALU port A wins on a shared index.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (wb_en) regs[b_idx] <= wb_data;
      if (wa_en) regs[a_idx] <= wa_data;
    end
  end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
  parameter int DW = 16
) (
  input  logic          mode,
  input  logic [3:0]    fn,
  input  logic          cin,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] f,
  output logic          cout,
  output logic          eq
);
  localparam logic [DW-1:0] ONES = '1;

  logic [DW-1:0] lg;
  logic [DW-1:0] x, y;
  logic [DW:0]   sum;

  always_comb begin
    case (fn)
      4'h0: lg = ~a;
      4'h1: lg = ~(a | b);
      4'h2: lg = ~a & b;
      4'h3: lg = '0;
      4'h4: lg = ~(a & b);
      4'h5: lg = ~b;
      4'h6: lg = a ^ b;
      4'h7: lg = a & ~b;
      4'h8: lg = ~a | b;
      4'h9: lg = ~(a ^ b);
      4'hA: lg = b;
      4'hB: lg = a & b;
      4'hC: lg = ONES;
      4'hD: lg = a | ~b;
      4'hE: lg = a | b;
      default: lg = a;
    endcase
  end

  // Arithmetic functions as a sum of two terms plus carry in.
  always_comb begin
    case (fn)
      4'h0: begin x = a;        y = '0;      end
      4'h1: begin x = a | b;    y = '0;      end
      4'h2: begin x = a | ~b;   y = '0;      end
      4'h3: begin x = '0;       y = ONES;    end
      4'h4: begin x = a;        y = a & ~b;  end
      4'h5: begin x = a | b;    y = a & ~b;  end
      4'h6: begin x = a;        y = ~b;      end
      4'h7: begin x = a & ~b;   y = ONES;    end
      4'h8: begin x = a;        y = a & b;   end
      4'h9: begin x = a;        y = b;       end
      4'hA: begin x = a | ~b;   y = a & b;   end
      4'hB: begin x = a & b;    y = ONES;    end
      4'hC: begin x = a;        y = a;       end
      4'hD: begin x = a | b;    y = a;       end
      4'hE: begin x = a | ~b;   y = a;       end
      default: begin x = a;     y = ONES;    end
    endcase
    sum = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
  end

  assign f    = mode ? lg : sum[DW-1:0];
  assign cout = mode ? 1'b0 : sum[DW];
  assign eq   = (f == ONES);

endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       ir_in,
  input  logic              alu_cout,
  input  logic              alu_eq,
  output cpu_pkg::uword_t   uw,
  output logic              is_fetch,
  output logic              cin,
  output logic              wb_en,
  output logic              load_en,
  output logic              flag_en,
  output logic              cy_q,
  output logic              eq_q
);
  import cpu_pkg::*;

  logic   exec_q;
  uword_t ir_q;

  assign is_fetch = !exec_q;
  assign uw       = is_fetch ? FETCH_WORD : ir_q;
  assign cin      = pick_cin(uw.csel, cy_q, eq_q);
  assign wb_en    = wb_allowed(uw.mode, uw.csel, cy_q, eq_q);
  assign load_en  = !is_fetch && uw.rd;
  assign flag_en  = !is_fetch && !uw.nlatch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_q <= 1'b0;
      ir_q   <= '0;
      cy_q   <= 1'b0;
      eq_q   <= 1'b0;
    end else begin
      exec_q <= !exec_q;
      if (is_fetch) ir_q <= ir_in;
      if (flag_en) begin
        cy_q <= alu_cout;
        eq_q <= alu_eq;
      end
    end
  end

endmodule

// File: rtl/cpu_core.sv
module cpu_core #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr
);
  import cpu_pkg::*;

  uword_t        uw;
  logic          is_fetch, cin, wb_en, load_en, flag_en, cy_q, eq_q;
  logic [DW-1:0] ra, rb, pc, alu_b, alu_f;
  logic          alu_cout, alu_eq;

  cpu_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_in    (mem_rdata[IRW-1:0]),
    .alu_cout (alu_cout),
    .alu_eq   (alu_eq),
    .uw       (uw),
    .is_fetch (is_fetch),
    .cin      (cin),
    .wb_en    (wb_en),
    .load_en  (load_en),
    .flag_en  (flag_en),
    .cy_q     (cy_q),
    .eq_q     (eq_q)
  );

  cpu_regfile #(.DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_idx   (uw.asel),
    .b_idx   (uw.bsel),
    .a_q     (ra),
    .b_q     (rb),
    .pc_q    (pc),
    .wa_en   (wb_en),
    .wa_data (alu_f),
    .wb_en   (load_en),
    .wb_data (mem_rdata)
  );

  assign alu_b = uw.rd ? mem_rdata : rb;

  cpu_alu #(.DW(DW)) u_alu (
    .mode (uw.mode),
    .fn   (uw.fn),
    .cin  (cin),
    .a    (ra),
    .b    (alu_b),
    .f    (alu_f),
    .cout (alu_cout),
    .eq   (alu_eq)
  );

  assign mem_addr  = ra;
  assign mem_wdata = rb;
  assign mem_rd    = uw.rd;
  assign mem_wr    = uw.wr;

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          is_fetch,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] pc,
  input logic          wb_en,
  input logic          mode,
  input logic [1:0]    csel,
  input logic          flag_en,
  input logic          cy_q,
  input logic          eq_q
);

  a_r2_fetch_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |=> !is_fetch);

  a_r2_exec_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !is_fetch |=> is_fetch);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |=> pc == $past(pc) + 1'b1);

  a_r3_fetch_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |-> (mem_rd && !mem_wr));

  a_r6_arith_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fetch && !mode) |-> wb_en);

  a_r7_never_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fetch && mode && csel == 2'b11) |-> !wb_en);

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> ($stable(cy_q) && $stable(eq_q)));

endmodule

bind cpu_core cpu_core_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .is_fetch (is_fetch),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .pc       (pc),
  .wb_en    (wb_en),
  .mode     (uw.mode),
  .csel     (uw.csel),
  .flag_en  (flag_en),
  .cy_q     (cy_q),
  .eq_q     (eq_q)
);

// File: tb/test_cpu_core.sv
module test_cpu_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] a;
    logic [15:0] d;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [15:0] mem [256];

  always #4 clk = ~clk;

  cpu_core #(.DW(16)) i_cpu_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) if (rst_n && mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  function automatic logic [15:0] enc(input bit rd, input bit wr, input int a, input int b,
                                      input bit nl, input int cs, input bit m, input int s);
    return {rd, wr, a[2:0], b[2:0], nl, cs[1:0], m, s[3:0]};
  endfunction

  function automatic logic [15:0] ldi(input int k);
    return enc(1, 0, 7, k, 1, 0, 0, 0);          // read into Rk, PC += 1
  endfunction
  function automatic logic [15:0] st(input int pa, input int pd);
    return enc(0, 1, pa, pd, 1, 3, 1, 15);       // write, logic F=A, never
  endfunction
  function automatic logic [15:0] jmp(input int tgt, input int cs);
    return enc(0, 0, 7, tgt, 1, cs, 1, 10);      // logic F=B into PC
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [15:0] a, input logic [15:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: every bus write pops one scoreboard item.
  always @(negedge clk) begin
    if (rst_n && mem_wr && !done) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 unexpected write: actual %h@%h expected none", mem_wdata, mem_addr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " addr"}, mem_addr, e.a);
        check({e.tag, " data"}, mem_wdata, e.d);
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h00] = ldi(1);  mem[8'h01] = 16'h1234;
    mem[8'h02] = ldi(2);  mem[8'h03] = 16'h1234;
    mem[8'h04] = ldi(3);  mem[8'h05] = 16'h0080;
    mem[8'h06] = ldi(4);  mem[8'h07] = 16'h0040;
    mem[8'h08] = enc(0, 0, 1, 2, 0, 3, 1, 9);    // compare R1,R2, no write
    mem[8'h09] = jmp(4, 2);                      // jump if EQ
    mem[8'h0A] = st(3, 3);                       // must be skipped
    mem[8'h40] = st(3, 1);
    mem[8'h41] = enc(0, 0, 1, 2, 0, 3, 0, 9);    // R1 = R1 + R2 + 0
    mem[8'h42] = st(3, 1);
    mem[8'h43] = enc(0, 0, 1, 2, 0, 3, 1, 9);    // compare unequal
    mem[8'h44] = jmp(4, 2);                      // not taken
    mem[8'h45] = st(3, 2);
    mem[8'h46] = ldi(5);  mem[8'h47] = 16'hFFFF;
    mem[8'h48] = ldi(6);  mem[8'h49] = 16'h0001;
    mem[8'h4A] = enc(0, 0, 5, 6, 0, 3, 0, 9);    // FFFF + 1 -> carry
    mem[8'h4B] = st(3, 5);
    mem[8'h4C] = ldi(4);  mem[8'h4D] = 16'h0060;
    mem[8'h4E] = jmp(4, 1);                      // jump if CY
    mem[8'h4F] = st(3, 3);                       // must be skipped
    mem[8'h60] = st(3, 6);
    mem[8'h61] = enc(0, 0, 6, 6, 1, 1, 0, 0);    // R6 = R6 + CY
    mem[8'h62] = st(3, 6);
    mem[8'h63] = enc(0, 0, 6, 6, 0, 0, 1, 0);    // R6 = ~R6, always
    mem[8'h64] = st(3, 6);
    mem[8'h65] = enc(0, 0, 7, 7, 1, 3, 0, 15);   // PC - 1: spin here

    push_exp(16'h0080, 16'h1234, "R9 R8 taken EQ jump, compare kept R1");
    push_exp(16'h0080, 16'h2468, "R6 R4 arithmetic add written");
    push_exp(16'h0080, 16'h1234, "R9 untaken jump falls through");
    push_exp(16'h0080, 16'h0000, "R4 add wraps with carry");
    push_exp(16'h0080, 16'h0001, "R7 R8 CY predicate taken, flag held");
    push_exp(16'h0080, 16'h0002, "R5 carry-in from CY");
    push_exp(16'h0080, 16'hFFFD, "R7 always-write logic NOT");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset addr", mem_addr, 16'h0000);
    check("R1 reset rd", {15'b0, mem_rd}, 16'h0001);
    check("R1 reset wr", {15'b0, mem_wr}, 16'h0000);
    rst_n = 1'b1;

    repeat (400) @(posedge clk);
    @(negedge clk);
    begin
      logic [15:0] a0, a1;
      a0 = mem_addr;
      @(negedge clk);
      a1 = mem_addr;
      check("R2 spin fetch/exec addresses", a0 ^ a1, 16'h0065 ^ 16'h0066);
      check("R2 spin lower address", (a0 < a1) ? a0 : a1, 16'h0065);
    end
    check("R3 all expected writes seen", 16'(sb.size()), 16'h0000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule